// File: doc/BRIEF.md
# Zero-page bit manipulation unit

This block is the execute stage for the single-bit and bit-mask operations of an 8-bit processor core. A sequencer hands it one command at a time. Each command carries the opcode byte, the accumulator, an immediate operand, the already computed operand address, the current program counter and a precomputed relative-branch target. The unit decodes the opcode and reads the memory operand when the operation needs it. It writes a modified byte back for read-modify-write forms. It then reports branch outcome, next program counter, flag results with per-flag update strobes, and the fixed cycle cost of the instruction.

The operations covered are: clear one selected bit; set one selected bit; branch when a selected bit is clear or set; test-and-set and test-and-reset of the bits under the accumulator mask; and the flag rules of the bit-test instruction in its memory and immediate forms. The bit index comes from the opcode itself, so one opcode column covers all eight bits.

Commands arrive on a valid/ready channel: the sequencer holds `cmd_valid` and the command fields until a clock edge where `cmd_ready` is high, and `cmd_ready` is high only while the unit is idle. Memory is reached through one request channel (valid/ready, the unit holds address, direction and write data stable until accepted) and one response channel (valid/ready, the memory holds `mem_rsp_valid` and data until the unit takes them). Results are presented during a single-cycle `done` pulse.

Top module: `zp_bitop_unit`

## Requirements
- R1: Opcodes with low nibble 4'h7 select a single-bit modify; opcode[7]=0 clears and opcode[7]=1 sets bit number opcode[6:4] of the byte read from `cmd_addr`, the byte written back differs from the one read only in that bit, and no flag strobe is raised.
- R2: Opcodes with low nibble 4'hF select a bit branch on bit opcode[6:4] of the byte at `cmd_addr`; opcode[7]=0 branches when the bit is 0, opcode[7]=1 when it is 1. When taken, `br_taken` is high during the `done` cycle and `br_target` and `pc_next` equal `cmd_target`; otherwise `br_taken` stays low and `pc_next` equals `cmd_pc`. No write and no flag strobe occur.
- R3: Opcodes 8'h04 and 8'h0C write back memory OR accumulator; opcodes 8'h14 and 8'h1C write back memory AND NOT accumulator. Both raise only the Z strobe, with Z = ((A AND M) == 0) computed from the byte before the write.
- R4: Opcodes 8'h24, 8'h2C, 8'h34 and 8'h3C read the byte at `cmd_addr` without writing it, and update Z = ((A AND M) == 0), N = M[7] and V = M[6] with all three strobes raised.
- R5: Opcode 8'h89 makes no memory access, takes its operand from `cmd_operand`, and raises only the Z strobe with Z = ((A AND operand) == 0).
- R6: `cost` during `done` is 5 for the R1 and R2 opcodes, 5 for 8'h04 and 8'h14, 6 for 8'h0C and 8'h1C, 3 for 8'h24, 4 for 8'h2C, 8'h34 and 8'h3C, and 2 for 8'h89 and every other opcode.
- R7: A read-modify-write command issues exactly one read then exactly one write, both to `cmd_addr`, and the write request is not raised before the read response has been accepted; read-only commands issue exactly one read.
- R8: Any opcode not named in R1 to R5 completes with no memory access, no flag strobe, no branch, and `pc_next` equal to `cmd_pc`.
- R9: `done` is high for exactly one cycle per accepted command, `cmd_ready` drops after acceptance until completion, and a memory request held without `mem_req_ready` keeps its address, direction and data unchanged.
- R10: After reset, `cmd_ready` is 1 and `mem_req_valid`, `mem_rsp_ready`, `done` and `br_taken` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Unit idle, command accepted on this edge if valid |
| cmd_opcode | input | 8 | Opcode byte |
| cmd_acc | input | 8 | Accumulator value |
| cmd_operand | input | 8 | Immediate operand |
| cmd_addr | input | 16 | Operand address |
| cmd_pc | input | 16 | Program counter after the instruction bytes |
| cmd_target | input | 16 | Precomputed branch target |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 16 | Request address |
| mem_req_wdata | output | 8 | Write data |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_ready | output | 1 | Unit waiting for read data |
| mem_rsp_rdata | input | 8 | Read data |
| done | output | 1 | One-cycle completion pulse |
| cost | output | 4 | Instruction cycle cost |
| br_taken | output | 1 | Branch taken, valid with done |
| br_target | output | 16 | Branch destination |
| pc_next | output | 16 | Program counter to continue from |
| flag_z | output | 1 | New Z value |
| flag_n | output | 1 | New N value |
| flag_v | output | 1 | New V value |
| upd_z | output | 1 | Write Z this cycle |
| upd_n | output | 1 | Write N this cycle |
| upd_v | output | 1 | Write V this cycle |

## Verification
The assertions take for granted that memory delivers exactly one response per read request and none otherwise, and that the sequencer only offers a command while the unit is free to finish it; they also rely on `mem_rsp_valid` being held until `mem_rsp_ready`. The stimulus keeps within this by running a memory model that answers each accepted read once after a pseudo-random delay of zero to three cycles, applies pseudo-random back-pressure on `mem_req_ready`, and issues one command at a time, waiting for `done` before the next. Every one of the 256 opcodes is swept with accumulator and memory patterns chosen to put the tested bit both set and clear.

// File: rtl/zpb_pkg.sv
package zpb_pkg;

  // Operation classes recognised by the decoder
  typedef enum logic [2:0] {
    K_NONE,
    K_CLR_BIT,
    K_SET_BIT,
    K_BR_CLR,
    K_BR_SET,
    K_TST_SET,
    K_TST_RST,
    K_BIT_TEST
  } op_kind_e;

  // Sequencer states
  typedef enum logic [2:0] {
    S_IDLE,
    S_RD,
    S_RWAIT,
    S_WR,
    S_DONE
  } seq_state_e;

  localparam int COST_W = 4;
  localparam logic [COST_W-1:0] COST_BITOP   = 4'd5;
  localparam logic [COST_W-1:0] COST_MASK_ZP = 4'd5;
  localparam logic [COST_W-1:0] COST_MASK_AB = 4'd6;
  localparam logic [COST_W-1:0] COST_TST_ZP  = 4'd3;
  localparam logic [COST_W-1:0] COST_TST_OTH = 4'd4;
  localparam logic [COST_W-1:0] COST_SHORT   = 4'd2;

endpackage

// File: rtl/zpb_decode.sv
module zpb_decode
  import zpb_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OP_W   = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic [OP_W-1:0]   opcode,
  output op_kind_e          kind,
  output logic [DATA_W-1:0] mask,
  output logic              needs_rd,
  output logic              needs_wr,
  output logic              is_imm,
  output logic [COST_W-1:0] cost
);

  // One-hot bit select from the opcode index field
  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign mask[i] = (opcode[4 +: IDX_W] == IDX_W'(i));
  end

  always_comb begin
    kind     = K_NONE;
    needs_rd = 1'b0;
    needs_wr = 1'b0;
    is_imm   = 1'b0;
    cost     = COST_SHORT;
    casez (opcode)
      8'b0???_0111: begin
        kind = K_CLR_BIT; needs_rd = 1'b1; needs_wr = 1'b1; cost = COST_BITOP;
      end
      8'b1???_0111: begin
        kind = K_SET_BIT; needs_rd = 1'b1; needs_wr = 1'b1; cost = COST_BITOP;
      end
      8'b0???_1111: begin
        kind = K_BR_CLR; needs_rd = 1'b1; cost = COST_BITOP;
      end
      8'b1???_1111: begin
        kind = K_BR_SET; needs_rd = 1'b1; cost = COST_BITOP;
      end
      8'h04: begin
        kind = K_TST_SET; needs_rd = 1'b1; needs_wr = 1'b1; cost = COST_MASK_ZP;
      end
      8'h0C: begin
        kind = K_TST_SET; needs_rd = 1'b1; needs_wr = 1'b1; cost = COST_MASK_AB;
      end
      8'h14: begin
        kind = K_TST_RST; needs_rd = 1'b1; needs_wr = 1'b1; cost = COST_MASK_ZP;
      end
      8'h1C: begin
        kind = K_TST_RST; needs_rd = 1'b1; needs_wr = 1'b1; cost = COST_MASK_AB;
      end
      8'h24: begin
        kind = K_BIT_TEST; needs_rd = 1'b1; cost = COST_TST_ZP;
      end
      8'h2C, 8'h34, 8'h3C: begin
        kind = K_BIT_TEST; needs_rd = 1'b1; cost = COST_TST_OTH;
      end
      8'h89: begin
        kind = K_BIT_TEST; is_imm = 1'b1; cost = COST_SHORT;
      end
      default: begin
        kind = K_NONE;
      end
    endcase
  end

endmodule

// File: rtl/zpb_alu.sv
module zpb_alu
  import zpb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  op_kind_e          kind,
  input  logic              is_imm,
  input  logic [DATA_W-1:0] mask,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] opnd,
  output logic [DATA_W-1:0] wdata,
  output logic              taken,
  output logic              new_z,
  output logic              new_n,
  output logic              new_v,
  output logic              upd_z,
  output logic              upd_n,
  output logic              upd_v
);

  logic [DATA_W-1:0] overlap;
  logic [DATA_W-1:0] sel_bit;

  assign overlap = acc & opnd;
  assign sel_bit = opnd & mask;
  assign new_z   = (overlap == '0);
  assign new_n   = opnd[DATA_W-1];
  assign new_v   = opnd[DATA_W-2];

  always_comb begin
    wdata = opnd;
    taken = 1'b0;
    upd_z = 1'b0;
    upd_n = 1'b0;
    upd_v = 1'b0;
    unique case (kind)
      K_CLR_BIT:  wdata = opnd & ~mask;
      K_SET_BIT:  wdata = opnd | mask;
      K_BR_CLR:   taken = (sel_bit == '0);
      K_BR_SET:   taken = (sel_bit != '0);
      K_TST_SET: begin
        wdata = opnd | acc;
        upd_z = 1'b1;
      end
      K_TST_RST: begin
        wdata = opnd & ~acc;
        upd_z = 1'b1;
      end
      K_BIT_TEST: begin
        upd_z = 1'b1;
        upd_n = !is_imm;
        upd_v = !is_imm;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/zpb_seq.sv
module zpb_seq
  import zpb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int OP_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [OP_W-1:0]   cmd_opcode,
  input  logic [DATA_W-1:0] cmd_acc,
  input  logic [DATA_W-1:0] cmd_operand,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [ADDR_W-1:0] cmd_pc,
  input  logic [ADDR_W-1:0] cmd_target,
  input  logic              needs_rd,
  input  logic              needs_wr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [DATA_W-1:0] mem_rsp_rdata,
  output logic              idle,
  output logic              done,
  output logic [OP_W-1:0]   op_q,
  output logic [DATA_W-1:0] acc_q,
  output logic [DATA_W-1:0] opnd_q,
  output logic [ADDR_W-1:0] pc_q,
  output logic [ADDR_W-1:0] tgt_q
);

  seq_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic              wr_pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      op_q      <= '0;
      acc_q     <= '0;
      opnd_q    <= '0;
      addr_q    <= '0;
      pc_q      <= '0;
      tgt_q     <= '0;
      wr_pend_q <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          if (cmd_valid) begin
            op_q      <= cmd_opcode;
            acc_q     <= cmd_acc;
            opnd_q    <= cmd_operand;
            addr_q    <= cmd_addr;
            pc_q      <= cmd_pc;
            tgt_q     <= cmd_target;
            wr_pend_q <= needs_wr;
            state_q   <= needs_rd ? S_RD : S_DONE;
          end
        end
        S_RD: begin
          if (mem_req_ready) state_q <= S_RWAIT;
        end
        S_RWAIT: begin
          if (mem_rsp_valid) begin
            opnd_q  <= mem_rsp_rdata;
            state_q <= wr_pend_q ? S_WR : S_DONE;
          end
        end
        S_WR: begin
          if (mem_req_ready) state_q <= S_DONE;
        end
        S_DONE: begin
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign idle          = (state_q == S_IDLE);
  assign cmd_ready     = idle;
  assign done          = (state_q == S_DONE);
  assign mem_req_valid = (state_q == S_RD) || (state_q == S_WR);
  assign mem_req_we    = (state_q == S_WR);
  assign mem_req_addr  = addr_q;
  assign mem_req_wdata = wr_data;
  assign mem_rsp_ready = (state_q == S_RWAIT);

  // Port-level history used by the ordering check
  logic              seen_rd_q;
  logic              seen_rsp_q;
  logic [ADDR_W-1:0] seen_addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_rd_q   <= 1'b0;
      seen_rsp_q  <= 1'b0;
      seen_addr_q <= '0;
    end else if (cmd_valid && cmd_ready) begin
      seen_rd_q   <= 1'b0;
      seen_rsp_q  <= 1'b0;
    end else begin
      if (mem_req_valid && mem_req_ready && !mem_req_we) begin
        seen_rd_q   <= 1'b1;
        seen_addr_q <= mem_req_addr;
      end
      if (mem_rsp_valid && mem_rsp_ready) seen_rsp_q <= 1'b1;
    end
  end

  // R7: a write only follows an accepted read response at the same address
  p_wr_after_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_we |-> seen_rd_q && seen_rsp_q && (mem_req_addr == seen_addr_q));

  // R9: a stalled request keeps its content
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_we) && $stable(mem_req_wdata));

  // R9: completion lasts one cycle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: no second command while one is in flight
  p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> !cmd_ready);

endmodule

// File: rtl/zp_bitop_unit.sv
module zp_bitop_unit
  import zpb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int OP_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [OP_W-1:0]   cmd_opcode,
  input  logic [DATA_W-1:0] cmd_acc,
  input  logic [DATA_W-1:0] cmd_operand,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [ADDR_W-1:0] cmd_pc,
  input  logic [ADDR_W-1:0] cmd_target,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [DATA_W-1:0] mem_rsp_rdata,
  output logic              done,
  output logic [COST_W-1:0] cost,
  output logic              br_taken,
  output logic [ADDR_W-1:0] br_target,
  output logic [ADDR_W-1:0] pc_next,
  output logic              flag_z,
  output logic              flag_n,
  output logic              flag_v,
  output logic              upd_z,
  output logic              upd_n,
  output logic              upd_v
);

  logic              idle;
  logic [OP_W-1:0]   op_q;
  logic [DATA_W-1:0] acc_q;
  logic [DATA_W-1:0] opnd_q;
  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] tgt_q;
  logic [OP_W-1:0]   dec_op;

  op_kind_e          kind;
  logic [DATA_W-1:0] mask;
  logic              needs_rd;
  logic              needs_wr;
  logic              is_imm;
  logic [DATA_W-1:0] wr_data;
  logic              taken;
  logic              a_upd_z;
  logic              a_upd_n;
  logic              a_upd_v;

  // Decode the incoming opcode while idle so dispatch needs no extra cycle
  assign dec_op = idle ? cmd_opcode : op_q;

  zpb_decode #(.DATA_W(DATA_W), .OP_W(OP_W)) u_decode (
    .opcode   (dec_op),
    .kind     (kind),
    .mask     (mask),
    .needs_rd (needs_rd),
    .needs_wr (needs_wr),
    .is_imm   (is_imm),
    .cost     (cost)
  );

  zpb_alu #(.DATA_W(DATA_W)) u_alu (
    .kind   (kind),
    .is_imm (is_imm),
    .mask   (mask),
    .acc    (acc_q),
    .opnd   (opnd_q),
    .wdata  (wr_data),
    .taken  (taken),
    .new_z  (flag_z),
    .new_n  (flag_n),
    .new_v  (flag_v),
    .upd_z  (a_upd_z),
    .upd_n  (a_upd_n),
    .upd_v  (a_upd_v)
  );

  zpb_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OP_W(OP_W)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_ready     (cmd_ready),
    .cmd_opcode    (cmd_opcode),
    .cmd_acc       (cmd_acc),
    .cmd_operand   (cmd_operand),
    .cmd_addr      (cmd_addr),
    .cmd_pc        (cmd_pc),
    .cmd_target    (cmd_target),
    .needs_rd      (needs_rd),
    .needs_wr      (needs_wr),
    .wr_data       (wr_data),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_we    (mem_req_we),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_ready (mem_rsp_ready),
    .mem_rsp_rdata (mem_rsp_rdata),
    .idle          (idle),
    .done          (done),
    .op_q          (op_q),
    .acc_q         (acc_q),
    .opnd_q        (opnd_q),
    .pc_q          (pc_q),
    .tgt_q         (tgt_q)
  );

  assign br_taken  = done & taken;
  assign br_target = tgt_q;
  assign pc_next   = taken ? tgt_q : pc_q;
  assign upd_z     = done & a_upd_z;
  assign upd_n     = done & a_upd_n;
  assign upd_v     = done & a_upd_v;

  // R1, R2: single-bit operations never touch flags
  p_bitop_no_flags_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done && (op_q[2:0] == 3'b111) |-> !upd_z && !upd_n && !upd_v);

  // R2: only the bit-branch column can take a branch
  p_taken_only_branch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |-> (op_q[3:0] == 4'hF));

  // R4: N and V are only written together with Z
  p_nv_with_z_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done && (upd_n || upd_v) |-> upd_z && upd_n && upd_v);

  // R5: the immediate form never reaches memory
  p_imm_no_mem_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && (cmd_opcode == 8'h89) |=> !mem_req_valid);

endmodule

// File: tb/zp_bitop_unit_tb_top.sv
module zp_bitop_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [7:0]  cmd_opcode = '0;
  logic [7:0]  cmd_acc = '0;
  logic [7:0]  cmd_operand = '0;
  logic [15:0] cmd_addr = '0;
  logic [15:0] cmd_pc = '0;
  logic [15:0] cmd_target = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic        mem_req_we;
  logic [15:0] mem_req_addr;
  logic [7:0]  mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic        mem_rsp_ready;
  logic [7:0]  mem_rsp_rdata = '0;
  logic        done;
  logic [3:0]  cost;
  logic        br_taken;
  logic [15:0] br_target;
  logic [15:0] pc_next;
  logic        flag_z, flag_n, flag_v;
  logic        upd_z, upd_n, upd_v;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  zp_bitop_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_opcode(cmd_opcode),
    .cmd_acc(cmd_acc), .cmd_operand(cmd_operand), .cmd_addr(cmd_addr),
    .cmd_pc(cmd_pc), .cmd_target(cmd_target),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_ready(mem_rsp_ready), .mem_rsp_rdata(mem_rsp_rdata),
    .done(done), .cost(cost), .br_taken(br_taken), .br_target(br_target),
    .pc_next(pc_next), .flag_z(flag_z), .flag_n(flag_n), .flag_v(flag_v),
    .upd_z(upd_z), .upd_n(upd_n), .upd_v(upd_v)
  );

  // Memory model: random back-pressure and 0..3 cycle read latency
  logic [7:0]  mem [256];
  logic [15:0] lfsr = 16'hACE1;
  int          rd_cnt = 0, wr_cnt = 0, rsp_cnt = 0, wr_rsp_snap = 0;
  logic [15:0] last_rd_addr = '0, last_wr_addr = '0;
  logic [7:0]  last_wr_data = '0;
  logic        pend = 1'b0;
  logic [1:0]  lat = '0;

  initial begin
    forever begin
      @(posedge clk);
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      mem_req_ready <= lfsr[0] | lfsr[3];
      if (mem_req_valid && mem_req_ready) begin
        if (mem_req_we) begin
          mem[mem_req_addr[7:0]] <= mem_req_wdata;
          wr_cnt       <= wr_cnt + 1;
          last_wr_addr <= mem_req_addr;
          last_wr_data <= mem_req_wdata;
          wr_rsp_snap  <= rsp_cnt;
        end else begin
          rd_cnt       <= rd_cnt + 1;
          last_rd_addr <= mem_req_addr;
          pend         <= 1'b1;
          lat          <= lfsr[2:1];
        end
      end
      if (pend && !mem_rsp_valid) begin
        if (lat == 2'd0) begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_rdata <= mem[last_rd_addr[7:0]];
          pend          <= 1'b0;
        end else begin
          lat <= lat - 2'd1;
        end
      end
      if (mem_rsp_valid && mem_rsp_ready) begin
        mem_rsp_valid <= 1'b0;
        rsp_cnt       <= rsp_cnt + 1;
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [7:0] op, input logic [7:0] a,
                         input logic [7:0] m, input logic [15:0] addr);
    logic [7:0]  msk, src, e_wd, opnd;
    logic        e_rd, e_wr, e_tk, e_uz, e_un, e_uv;
    logic [3:0]  e_cost;
    logic [15:0] pc, tgt;
    string       req;
    int          rd0, wr0, rsp0, n;
    msk  = 8'(1 << op[6:4]);
    opnd = ~m ^ 8'h3C;
    pc   = {op, a} + 16'd3;
    tgt  = pc ^ 16'h5A5A;
    e_rd = 0; e_wr = 0; e_tk = 0; e_uz = 0; e_un = 0; e_uv = 0;
    e_cost = 4'd2; e_wd = m; src = m; req = "R8";
    if (op[3:0] == 4'h7) begin
      req = "R1"; e_rd = 1; e_wr = 1; e_cost = 4'd5;
      e_wd = op[7] ? (m | msk) : (m & ~msk);
    end else if (op[3:0] == 4'hF) begin
      req = "R2"; e_rd = 1; e_cost = 4'd5;
      e_tk = op[7] ? ((m & msk) != 0) : ((m & msk) == 0);
    end else if (op == 8'h04 || op == 8'h0C) begin
      req = "R3"; e_rd = 1; e_wr = 1; e_uz = 1; e_wd = m | a;
      e_cost = (op == 8'h04) ? 4'd5 : 4'd6;
    end else if (op == 8'h14 || op == 8'h1C) begin
      req = "R3"; e_rd = 1; e_wr = 1; e_uz = 1; e_wd = m & ~a;
      e_cost = (op == 8'h14) ? 4'd5 : 4'd6;
    end else if (op == 8'h24 || op == 8'h2C || op == 8'h34 || op == 8'h3C) begin
      req = "R4"; e_rd = 1; e_uz = 1; e_un = 1; e_uv = 1;
      e_cost = (op == 8'h24) ? 4'd3 : 4'd4;
    end else if (op == 8'h89) begin
      req = "R5"; e_uz = 1; src = opnd;
    end
    mem[addr[7:0]] = m;
    rd0 = rd_cnt; wr0 = wr_cnt; rsp0 = rsp_cnt;
    @(negedge clk);
    cmd_opcode = op; cmd_acc = a; cmd_operand = opnd; cmd_addr = addr;
    cmd_pc = pc; cmd_target = tgt; cmd_valid = 1'b1;
    chk("R9", "ready before accept", int'(cmd_ready), 1);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    n = 0;
    while (!done && n < 200) begin
      chk("R9", "ready while busy", int'(cmd_ready), 0);
      @(negedge clk);
      n++;
    end
    chk("R9", "completion", int'(done), 1);
    // R6 cost table
    chk("R6", "cost", int'(cost), int'(e_cost));
    chk(req, "br_taken", int'(br_taken), int'(e_tk));
    chk(req, "pc_next", int'(pc_next), e_tk ? int'(tgt) : int'(pc));
    if (e_tk) chk("R2", "br_target", int'(br_target), int'(tgt));
    // R7 memory traffic
    chk("R7", "reads", rd_cnt - rd0, int'(e_rd));
    chk("R7", "writes", wr_cnt - wr0, int'(e_wr));
    if (e_rd) chk("R7", "read addr", int'(last_rd_addr), int'(addr));
    if (e_wr) begin
      chk("R7", "write addr", int'(last_wr_addr), int'(addr));
      chk("R7", "write after rsp", wr_rsp_snap - rsp0, 1);
      chk(req, "write data", int'(last_wr_data), int'(e_wd));
    end
    chk(req, "upd_z", int'(upd_z), int'(e_uz));
    chk(req, "upd_n", int'(upd_n), int'(e_un));
    chk(req, "upd_v", int'(upd_v), int'(e_uv));
    if (e_uz) chk(req, "flag_z", int'(flag_z), int'((a & src) == 8'h00));
    if (e_un) begin
      chk(req, "flag_n", int'(flag_n), int'(src[7]));
      chk(req, "flag_v", int'(flag_v), int'(src[6]));
    end
    @(negedge clk);
    chk("R9", "done pulse", int'(done), 0);
    chk("R9", "taken pulse", int'(br_taken), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] a, m;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", "cmd_ready", int'(cmd_ready), 1);
    chk("R10", "mem_req_valid", int'(mem_req_valid), 0);
    chk("R10", "mem_rsp_ready", int'(mem_rsp_ready), 0);
    chk("R10", "done", int'(done), 0);
    chk("R10", "br_taken", int'(br_taken), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int op = 0; op < 256; op++) begin
      for (int k = 0; k < 6; k++) begin
        case (k)
          0: begin a = 8'h00; m = 8'h00; end
          1: begin a = 8'hFF; m = 8'hFF; end
          2: begin a = 8'(op); m = ~8'(op); end
          3: begin a = 8'h55; m = 8'(1 << op[6:4]); end
          4: begin a = 8'hAA; m = ~8'(1 << op[6:4]); end
          default: begin a = 8'(op * 7 + 13); m = 8'(op * 29 + k); end
        endcase
        run_cmd(8'(op), a, m, {8'(k * 17 + 1), 8'(op)});
      end
    end
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule